// File: doc/BRIEF.md
# Debounced Input Transition Interrupt

This block watches a group of general-purpose input pins and raises a latching, active-low interrupt when any watched pin changes level. Each pin first passes through a two-flop synchronizer. A per-pin debounce filter can then be switched in. With the filter on, a new level is accepted only after the pin has held it for a programmable number of sample ticks. The block compares the filtered level of each pin with a stored reference value. Only pins marked as inputs take part in that comparison.

A small register port lets a host set up the block. It can choose which pins are debounced, which pins are inputs, which input pins may raise the interrupt, and the debounce length. It can also read two latched flags. The transition flag reports that some input pin changed. The interrupt flag reports that an interrupt-enabled input pin changed. Reading the input snapshot returns the filtered levels, copies them into the reference, and clears both flags. This read is how the host acknowledges an interrupt.

Top module: `intr_pin_monitor`

## Requirements
- R1: After a synchronous reset, all masks, the threshold, the reference and both flags are zero, and `irq_n` is released.
- R2: With debounce off, a pin change that is set up before a clock edge sets the flags on the third rising edge, counting that edge as the first. The delay comes from two synchronizer stages.
- R3: With debounce on, the filtered level takes a new value only on a sample tick, after the synchronized pin has differed from it on `thr` consecutive ticks. A threshold of 0 acts as 1. A pulse shorter than that is ignored. One sample tick occurs every `TICK_DIV` clocks.
- R4: Debounce is selected separately for each pin. A pin whose debounce bit is 0 uses its synchronized level directly, so even a two-cycle pulse is seen.
- R5: The transition flag (status bit 6) is set when the filtered level of any input pin differs from its reference. It then stays set until a snapshot read.
- R6: The interrupt flag (status bit 7) is set when an input pin that is also enabled in the interrupt mask differs from its reference. It stays set after the pin returns to its old level, until a snapshot read.
- R7: A pin whose direction bit is 0 (output) never sets either flag.
- R8: A read of address 0 returns the filtered levels of all pins, loads them as the new reference, and clears both flags. A read of the status register does not clear anything.
- R9: The register map is as follows. Address 1 is debounce enable. Address 2 is the interrupt mask. Address 3 is direction, where 1 means input. Address 5 is the threshold, held in the low `CNT_W` bits. Address 4 is read-only status: bits 7 and 6 hold the flags, all other bits read 0, and writes to it are ignored. Read data appears on the cycle after the read strobe.
- R10: `irq_n` is driven 0 while the interrupt flag is set and is high impedance otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pins_i | input | NPINS | Asynchronous pin levels |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| irq_n | output | 1 | Open-drain-style interrupt, 0 when asserted |

## Verification
The assertions check every cycle that a snapshot read clears both flags. They also check that both flags hold once set, that the interrupt flag never stands without the transition flag, and that a debounced level never moves except on a sample tick. The bench scenarios cover the rest by comparing against a cycle model. These include the exact synchronizer latency, the glitch rejection and acceptance lengths, the zero-threshold case, the way output-direction pins and unmasked pins are handled, and the register read-back values.

// File: rtl/intr_pkg.sv
package intr_pkg;
  localparam logic [2:0] ADDR_SNAP  = 3'd0;
  localparam logic [2:0] ADDR_DEBEN = 3'd1;
  localparam logic [2:0] ADDR_IMASK = 3'd2;
  localparam logic [2:0] ADDR_DIR   = 3'd3;
  localparam logic [2:0] ADDR_STAT  = 3'd4;
  localparam logic [2:0] ADDR_THR   = 3'd5;
  localparam int STAT_INT_BIT   = 7;
  localparam int STAT_TRANS_BIT = 6;
endpackage

// File: rtl/intr_sync.sv
module intr_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/intr_tick.sv
module intr_tick #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt_q;

  assign tick = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/intr_debounce.sv
module intr_debounce #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             en,
  input  logic [CNT_W-1:0] thr,
  input  logic             din,
  output logic             lvl
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   thr_eff;
  logic [CNT_W:0]   cnt_next;

  assign thr_eff  = (thr == '0) ? (CNT_W+1)'(1) : {1'b0, thr};
  assign cnt_next = {1'b0, cnt_q} + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl   <= 1'b0;
      cnt_q <= '0;
    end else if (!en || din == lvl) begin
      lvl   <= din;
      cnt_q <= '0;
    end else if (tick) begin
      if (cnt_next >= thr_eff) begin
        lvl   <= din;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_next[CNT_W-1:0];
      end
    end
  end
endmodule

// File: rtl/intr_pin_monitor.sv
module intr_pin_monitor
  import intr_pkg::*;
#(
  parameter int NPINS    = 8,
  parameter int CNT_W    = 4,
  parameter int TICK_DIV = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] pins_i,
  input  logic             reg_we,
  input  logic             reg_re,
  input  logic [2:0]       reg_addr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  output logic             irq_n
);
  logic [NPINS-1:0] pin_sync;
  logic [NPINS-1:0] deb_lvl;
  logic [NPINS-1:0] filt;
  logic [NPINS-1:0] diff;
  logic [NPINS-1:0] deb_en_q, imask_q, dir_q, ref_q;
  logic [CNT_W-1:0] thr_q;
  logic             trans_q, int_q;
  logic             tick;
  logic             snap_rd;

  intr_sync #(.W(NPINS)) u_sync (
    .clk(clk), .rst(rst), .d(pins_i), .q(pin_sync)
  );

  intr_tick #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst(rst), .tick(tick)
  );

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    intr_debounce #(.CNT_W(CNT_W)) u_deb (
      .clk(clk), .rst(rst), .tick(tick), .en(deb_en_q[i]),
      .thr(thr_q), .din(pin_sync[i]), .lvl(deb_lvl[i])
    );
    assign filt[i] = deb_en_q[i] ? deb_lvl[i] : pin_sync[i];
  end

  assign diff    = (filt ^ ref_q) & dir_q;
  assign snap_rd = reg_re && (reg_addr == ADDR_SNAP);

  // reference and latched flags
  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q   <= '0;
      trans_q <= 1'b0;
      int_q   <= 1'b0;
    end else if (snap_rd) begin
      ref_q   <= filt;
      trans_q <= 1'b0;
      int_q   <= 1'b0;
    end else begin
      if (|diff)             trans_q <= 1'b1;
      if (|(diff & imask_q)) int_q   <= 1'b1;
    end
  end

  // configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      deb_en_q <= '0;
      imask_q  <= '0;
      dir_q    <= '0;
      thr_q    <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        ADDR_DEBEN: deb_en_q <= reg_wdata[NPINS-1:0];
        ADDR_IMASK: imask_q  <= reg_wdata[NPINS-1:0];
        ADDR_DIR:   dir_q    <= reg_wdata[NPINS-1:0];
        ADDR_THR:   thr_q    <= reg_wdata[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  // registered read data
  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_re) begin
      case (reg_addr)
        ADDR_SNAP:  reg_rdata <= 8'(filt);
        ADDR_DEBEN: reg_rdata <= 8'(deb_en_q);
        ADDR_IMASK: reg_rdata <= 8'(imask_q);
        ADDR_DIR:   reg_rdata <= 8'(dir_q);
        ADDR_STAT: begin
          reg_rdata                 <= '0;
          reg_rdata[STAT_INT_BIT]   <= int_q;
          reg_rdata[STAT_TRANS_BIT] <= trans_q;
        end
        ADDR_THR:   reg_rdata <= 8'(thr_q);
        default:    reg_rdata <= '0;
      endcase
    end
  end

  assign irq_n = int_q ? 1'b0 : 1'bz;
endmodule

// File: rtl/intr_pin_monitor_chk.sv
module intr_pin_monitor_chk #(
  parameter int NPINS = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             snap_rd,
  input logic             tick,
  input logic [NPINS-1:0] deb_en,
  input logic [NPINS-1:0] lvl,
  input logic             int_q,
  input logic             trans_q
);
  assert_snap_clears_R8: assert property (@(posedge clk) disable iff (rst)
    snap_rd |=> (!int_q && !trans_q));

  assert_int_latches_R6: assert property (@(posedge clk) disable iff (rst)
    (int_q && !snap_rd) |=> int_q);

  assert_trans_latches_R5: assert property (@(posedge clk) disable iff (rst)
    (trans_q && !snap_rd) |=> trans_q);

  assert_int_needs_trans_R5: assert property (@(posedge clk) disable iff (rst)
    int_q |-> trans_q);

  for (genvar i = 0; i < NPINS; i++) begin : g_chk
    assert_deb_only_on_tick_R3: assert property (@(posedge clk) disable iff (rst)
      (deb_en[i] && !tick) |=> $stable(lvl[i]));
  end
endmodule

bind intr_pin_monitor intr_pin_monitor_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst(rst), .snap_rd(snap_rd), .tick(tick),
  .deb_en(deb_en_q), .lvl(deb_lvl), .int_q(int_q), .trans_q(trans_q)
);

// File: tb/test_intr_pin_monitor.sv
module test_intr_pin_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int NP  = 8;
  localparam int CW  = 4;
  localparam int DIV = 4;

  logic          clk = 0;
  logic          rst = 1;
  logic [NP-1:0] pins = '0;
  logic          we = 0, re = 0;
  logic [2:0]    addr = '0;
  logic [7:0]    wdata = '0;
  logic [7:0]    rdata;
  wire           irq_line;
  pullup (irq_line);

  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  intr_pin_monitor #(.NPINS(NP), .CNT_W(CW), .TICK_DIV(DIV)) i_intr_pin_monitor (
    .clk(clk), .rst(rst), .pins_i(pins), .reg_we(we), .reg_re(re),
    .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata), .irq_n(irq_line)
  );

  // behavioural reference model
  logic [NP-1:0] m_s1, m_s2, m_lvl, m_deb, m_imask, m_dir, m_ref;
  logic [NP-1:0] m_filt, m_diff;
  int            m_cnt [NP];
  int            m_tc, m_thr, m_thr_e;
  bit            m_tick, m_trans, m_int;
  logic [7:0]    m_rd;
  string         m_tag = "R1";

  always @(posedge clk) begin
    if (rst) begin
      m_s1 = '0; m_s2 = '0; m_lvl = '0; m_deb = '0; m_imask = '0;
      m_dir = '0; m_ref = '0; m_tc = 0; m_thr = 0; m_trans = 0;
      m_int = 0; m_rd = '0;
      foreach (m_cnt[i]) m_cnt[i] = 0;
    end else begin
      m_tick = (m_tc == DIV-1);
      for (int i = 0; i < NP; i++) m_filt[i] = m_deb[i] ? m_lvl[i] : m_s2[i];
      m_diff = (m_filt ^ m_ref) & m_dir;
      if (re) begin
        case (addr)
          3'd0: begin m_rd = m_filt; m_tag = "R8"; end
          3'd1: begin m_rd = m_deb; m_tag = "R9"; end
          3'd2: begin m_rd = m_imask; m_tag = "R9"; end
          3'd3: begin m_rd = m_dir; m_tag = "R9"; end
          3'd4: begin m_rd = {m_int, m_trans, 6'b0}; m_tag = "R5"; end
          3'd5: begin m_rd = 8'(m_thr); m_tag = "R9"; end
          default: begin m_rd = 8'h00; m_tag = "R9"; end
        endcase
      end
      if (re && addr == 3'd0) begin
        m_ref = m_filt; m_trans = 0; m_int = 0;
      end else begin
        if (m_diff != 0) m_trans = 1;
        if ((m_diff & m_imask) != 0) m_int = 1;
      end
      m_thr_e = (m_thr == 0) ? 1 : m_thr;
      for (int i = 0; i < NP; i++) begin
        if (!m_deb[i] || m_s2[i] == m_lvl[i]) begin
          m_lvl[i] = m_s2[i]; m_cnt[i] = 0;
        end else if (m_tick) begin
          if (m_cnt[i] + 1 >= m_thr_e) begin m_lvl[i] = m_s2[i]; m_cnt[i] = 0; end
          else m_cnt[i] = m_cnt[i] + 1;
        end
      end
      if (we) begin
        case (addr)
          3'd1: m_deb   = wdata[NP-1:0];
          3'd2: m_imask = wdata[NP-1:0];
          3'd3: m_dir   = wdata[NP-1:0];
          3'd5: m_thr   = int'(wdata[CW-1:0]);
          default: ;
        endcase
      end
      m_s2 = m_s1;
      m_s1 = pins;
      m_tc = (m_tc == DIV-1) ? 0 : m_tc + 1;
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (irq_line !== (m_int ? 1'b0 : 1'b1)) begin
        fails++;
        $display("FAIL R10 irq_n act=%b exp=%b t=%0t", irq_line, !m_int, $time);
      end
      checks++;
      if (rdata !== m_rd) begin
        fails++;
        $display("FAIL %s rdata act=%h exp=%h t=%0t", m_tag, rdata, m_rd, $time);
      end
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk); re = 1; addr = a;
    @(negedge clk); re = 0;
    chk(tag, rdata, exp);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 irq released", {7'b0, irq_line}, 8'h01);
    rd(3'd4, 8'h00, "R1 status");
    rd(3'd1, 8'h00, "R1 deben");
    rd(3'd3, 8'h00, "R1 dir");

    wr(3'd3, 8'hFF); wr(3'd2, 8'h0F); wr(3'd5, 8'h03);
    rd(3'd3, 8'hFF, "R9 dir readback");
    rd(3'd2, 8'h0F, "R9 imask readback");
    rd(3'd5, 8'h03, "R9 thr readback");
    wr(3'd4, 8'hFF);
    rd(3'd4, 8'h00, "R9 status write ignored");

    // R2 latency without debounce
    @(negedge clk); pins = 8'h01;
    wait_cyc(2);
    chk("R2 not yet", {7'b0, irq_line}, 8'h01);
    wait_cyc(1);
    chk("R2 asserted", {7'b0, irq_line}, 8'h00);
    pins = 8'h00;
    wait_cyc(5);
    chk("R6 latched", {7'b0, irq_line}, 8'h00);
    rd(3'd4, 8'hC0, "R6 status");
    rd(3'd4, 8'hC0, "R8 status read keeps flags");
    rd(3'd0, 8'h00, "R8 snapshot");
    rd(3'd4, 8'h00, "R8 cleared");

    // R7 output-direction pin ignored
    wr(3'd3, 8'h7F);
    pins = 8'h80;
    wait_cyc(10);
    rd(3'd4, 8'h00, "R7 status");
    chk("R7 irq", {7'b0, irq_line}, 8'h01);
    rd(3'd0, 8'h80, "R8 snapshot level");
    pins = 8'h00;
    wait_cyc(5);
    rd(3'd0, 8'h00, "R8 snapshot level");
    wr(3'd3, 8'hFF);

    // R5 unmasked input: transition only
    pins = 8'h20;
    wait_cyc(5);
    rd(3'd4, 8'h40, "R5 trans only");
    chk("R5 irq", {7'b0, irq_line}, 8'h01);
    rd(3'd0, 8'h20, "R8 snapshot");
    rd(3'd4, 8'h00, "R8 cleared");
    pins = 8'h00;
    wait_cyc(5);
    rd(3'd0, 8'h00, "R8 snapshot");

    // R3 debounce on pin 1, thr 3
    wr(3'd1, 8'h02);
    rd(3'd1, 8'h02, "R9 deben readback");
    pins = 8'h02;
    wait_cyc(4);
    pins = 8'h00;
    wait_cyc(20);
    rd(3'd4, 8'h00, "R3 glitch rejected");
    pins = 8'h02;
    wait_cyc(40);
    rd(3'd4, 8'hC0, "R3 held level accepted");
    rd(3'd0, 8'h02, "R3 snapshot");
    pins = 8'h00;
    wait_cyc(40);
    rd(3'd0, 8'h00, "R3 snapshot low");

    // R4 non-debounced pin sees short pulse
    pins = 8'h04;
    wait_cyc(2);
    pins = 8'h00;
    wait_cyc(10);
    rd(3'd4, 8'hC0, "R4 short pulse seen");
    rd(3'd0, 8'h00, "R4 snapshot");
    rd(3'd4, 8'h00, "R8 cleared");

    // R3 threshold 0 acts as 1
    wr(3'd5, 8'h00);
    wr(3'd1, 8'h01);
    pins = 8'h01;
    wait_cyc(12);
    rd(3'd4, 8'hC0, "R3 thr zero");
    rd(3'd0, 8'h01, "R3 thr zero snapshot");
    rd(3'd5, 8'h00, "R9 thr readback");

    wait_cyc(4);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule